// File: doc/BRIEF.md
# Program Counter Sampling Register Bank

This block is a small memory-mapped slave that lets an external debugger observe where a running processor is executing, without halting it. Every cycle the core presents its current program counter, context identifier, virtual machine identifier and execution state. The block registers these live values one cycle later. Reading the low program-counter sample word returns the lower half of the registered PC. On the same clock edge, that read copies the upper PC half, the context identifier and a packed state word into shadow registers. Later reads of those shadow registers therefore describe the same instant as the low word.

When the core reports that it is in debug state or that profiling is forbidden, the low sample word reads as all-ones and the shadows keep their previous contents. Two read-only identification words report how much of the sampling set is built and which PC offset convention software must apply. Both values come from elaboration-time parameters. The sampling-level parameter also decides which shadow registers exist. A shadow register that is not built reads as zero. Writes to the bank are accepted on the bus but change nothing.

Top module: `pcs_bank`

## Requirements
- R1: Registers decode on the word address (address bits 1:0 ignored): PC low 0x0A0, context ID 0x0A4, state word 0x0A8, PC high 0x0AC, offset-convention ID 0xFC4, level ID 0xFC8. Every other offset reads zero.
- R2: A read access to 0x0A0 returns bits 31:0 of the registered PC. At the clock edge that ends this access, the PC high, context ID and state shadows load the registered core values.
- R3: When the registered prohibit flag is set, a read of 0x0A0 returns 0xFFFFFFFF and all shadow registers keep their previous values.
- R4: Core inputs are registered once before use. A read of 0x0A0 in the same cycle that the core PC changes returns, and captures, the PC from before the change, so the low and high words come from the same sample.
- R5: The state word has the following layout: bit 31 is the non-secure flag, bit 30 is set when the exception level is 2, bit 29 is set when the exception level is 3, bit 28 is the 64-bit-state flag, bits 7:0 (the VMID width) hold the VMID, and all other bits are zero.
- R6: The word at 0xFC8 holds the LEVEL parameter in bits 3:0 and zero above. The encodings are: 0 means nothing is sampled, 1 means PC only, 2 means PC and context ID, 3 means PC, context ID and state.
- R7: The word at 0xFC4 holds the OFFSET_MODE parameter in bits 3:0 and zero above. The encodings are: 0 means the offset depends on instruction state, 1 means no offset, 2 means no offset and no sampling in 32-bit state.
- R8: A sample register that LEVEL does not build reads zero: the context ID when LEVEL < 2, the state word when LEVEL < 3, and both PC words when LEVEL = 0.
- R9: Bus writes to any offset change no register contents.
- R10: When OFFSET_MODE is 2 and the registered 64-bit-state flag is clear, a read of 0x0A0 behaves as a prohibited read: it returns all-ones and leaves the shadows unchanged.
- R11: Reset clears every shadow register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data (discarded) |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| core_pc | input | PC_W | Live program counter |
| core_cid | input | CID_W | Live context identifier |
| core_vmid | input | VMID_W | Live virtual machine identifier |
| core_ns | input | 1 | Core is in non-secure state |
| core_el | input | 2 | Current exception level |
| core_aa64 | input | 1 | Core is in 64-bit state |
| core_prohibit | input | 1 | Core is in debug state or profiling is forbidden |

## Verification
The bench checks the timing of the core-input registers. It moves the core PC in the same cycle as a sample read. A design that captured the live input directly would then return a low word and a high word taken from different PCs. It also sets the prohibit flag, and separately clears the 64-bit-state flag under offset mode 2, and then moves the PC. A design that updated its shadows on a blocked read would show the new upper word on the next read of 0x0AC. A second instance built with LEVEL 1 must read zero for the context ID and state word, and must report its own parameter values in both ID words. Writes to every sample and ID offset are followed by read-backs, which expose any register that accepts bus data.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   localparam int unsigned BUS_W = 32;

   localparam logic [11:0] OFS_PC_LO  = 12'h0A0;
   localparam logic [11:0] OFS_CID    = 12'h0A4;
   localparam logic [11:0] OFS_STATE  = 12'h0A8;
   localparam logic [11:0] OFS_PC_HI  = 12'h0AC;
   localparam logic [11:0] OFS_OFSID  = 12'hFC4;
   localparam logic [11:0] OFS_LVLID  = 12'hFC8;

   localparam logic [BUS_W-1:0] BLOCKED_WORD = '1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PC_LO,
      SEL_CID,
      SEL_STATE,
      SEL_PC_HI,
      SEL_OFSID,
      SEL_LVLID
   } reg_sel_e;

   // Packs execution state into the layout software decodes.
   function automatic logic [BUS_W-1:0] pack_state(input logic ns,
                                                   input logic [1:0] el,
                                                   input logic aa64,
                                                   input logic [15:0] vmid);
      logic [BUS_W-1:0] w;
      w        = '0;
      w[31]    = ns;
      w[30]    = (el == 2'd2);
      w[29]    = (el == 2'd3);
      w[28]    = aa64;
      w[15:0]  = vmid;
      return w;
   endfunction

endpackage

// File: rtl/pcs_live_stage.sv
module pcs_live_stage
   import pcs_pkg::*;
#(
   parameter int unsigned PC_W        = 64,
   parameter int unsigned CID_W       = 32,
   parameter int unsigned VMID_W      = 8,
   parameter int unsigned OFFSET_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   core_pc,
   input  logic [CID_W-1:0]  core_cid,
   input  logic [VMID_W-1:0] core_vmid,
   input  logic              core_ns,
   input  logic [1:0]        core_el,
   input  logic              core_aa64,
   input  logic              core_prohibit,
   output logic [PC_W-1:0]   live_pc,
   output logic [CID_W-1:0]  live_cid,
   output logic [BUS_W-1:0]  live_state,
   output logic              live_block
);

   localparam bit NO_AA32_SAMPLE = (OFFSET_MODE == 2);

   logic             block_d;
   logic [BUS_W-1:0] state_d;

   always_comb begin
      block_d = core_prohibit | (NO_AA32_SAMPLE & ~core_aa64);
      state_d = pack_state(core_ns, core_el, core_aa64, 16'(core_vmid));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_pc    <= '0;
         live_cid   <= '0;
         live_state <= '0;
         live_block <= 1'b1;
      end else begin
         live_pc    <= core_pc;
         live_cid   <= core_cid;
         live_state <= state_d;
         live_block <= block_d;
      end
   end

endmodule

// File: rtl/pcs_capture.sv
module pcs_capture
   import pcs_pkg::*;
#(
   parameter int unsigned PC_W  = 64,
   parameter int unsigned CID_W = 32,
   parameter int unsigned LEVEL = 3,
   localparam int unsigned HI_W = PC_W - 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [HI_W-1:0]  live_pc_hi,
   input  logic [CID_W-1:0] live_cid,
   input  logic [BUS_W-1:0] live_state,
   output logic [HI_W-1:0]  sh_pc_hi,
   output logic [CID_W-1:0] sh_cid,
   output logic [BUS_W-1:0] sh_state
);

   generate
      if (LEVEL >= 1) begin : g_pc_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sh_pc_hi <= '0;
            else if (sample_en) sh_pc_hi <= live_pc_hi;
         end
      end else begin : g_no_pc_hi
         logic unused_pc_hi;
         assign unused_pc_hi = ^{live_pc_hi, sample_en};
         assign sh_pc_hi     = '0;
      end

      if (LEVEL >= 2) begin : g_cid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sh_cid <= '0;
            else if (sample_en) sh_cid <= live_cid;
         end
      end else begin : g_no_cid
         logic unused_cid;
         assign unused_cid = ^live_cid;
         assign sh_cid     = '0;
      end

      if (LEVEL >= 3) begin : g_state
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sh_state <= '0;
            else if (sample_en) sh_state <= live_state;
         end
      end else begin : g_no_state
         logic unused_state;
         assign unused_state = ^live_state;
         assign sh_state     = '0;
      end
   endgenerate

endmodule

// File: rtl/pcs_read_mux.sv
module pcs_read_mux
   import pcs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned LEVEL       = 3,
   parameter int unsigned OFFSET_MODE = 0
) (
   input  logic              rd_phase,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [BUS_W-1:0]  live_pc_lo,
   input  logic              live_block,
   input  logic [BUS_W-1:0]  sh_pc_hi,
   input  logic [BUS_W-1:0]  sh_cid,
   input  logic [BUS_W-1:0]  sh_state,
   output reg_sel_e          sel,
   output logic [BUS_W-1:0]  prdata
);

   localparam logic [BUS_W-1:0] LVL_WORD = BUS_W'(LEVEL);
   localparam logic [BUS_W-1:0] OFS_WORD = BUS_W'(OFFSET_MODE);
   localparam bit HAS_PC = (LEVEL >= 1);

   logic [ADDR_W-1:0] waddr;

   always_comb begin
      waddr = {paddr[ADDR_W-1:2], 2'b00};
      sel   = SEL_NONE;
      if      (waddr == ADDR_W'(OFS_PC_LO)) sel = SEL_PC_LO;
      else if (waddr == ADDR_W'(OFS_CID))   sel = SEL_CID;
      else if (waddr == ADDR_W'(OFS_STATE)) sel = SEL_STATE;
      else if (waddr == ADDR_W'(OFS_PC_HI)) sel = SEL_PC_HI;
      else if (waddr == ADDR_W'(OFS_OFSID)) sel = SEL_OFSID;
      else if (waddr == ADDR_W'(OFS_LVLID)) sel = SEL_LVLID;
   end

   always_comb begin
      prdata = '0;
      if (rd_phase) begin
         unique case (sel)
            SEL_PC_LO: prdata = !HAS_PC   ? '0 :
                                live_block ? BLOCKED_WORD : live_pc_lo;
            SEL_CID:   prdata = sh_cid;
            SEL_STATE: prdata = sh_state;
            SEL_PC_HI: prdata = sh_pc_hi;
            SEL_OFSID: prdata = OFS_WORD;
            SEL_LVLID: prdata = LVL_WORD;
            default:   prdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pcs_bank.sv
module pcs_bank
   import pcs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned PC_W        = 64,
   parameter int unsigned CID_W       = 32,
   parameter int unsigned VMID_W      = 8,
   parameter int unsigned LEVEL       = 3,
   parameter int unsigned OFFSET_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   input  logic [PC_W-1:0]   core_pc,
   input  logic [CID_W-1:0]  core_cid,
   input  logic [VMID_W-1:0] core_vmid,
   input  logic              core_ns,
   input  logic [1:0]        core_el,
   input  logic              core_aa64,
   input  logic              core_prohibit
);

   localparam int unsigned HI_W = PC_W - 32;

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("pcs_bank: ADDR_W must be at least 12");
      end
      if (PC_W < 33 || PC_W > 64) begin : g_bad_pc
         $error("pcs_bank: PC_W must lie in 33..64");
      end
      if (CID_W < 1 || CID_W > 32) begin : g_bad_cid
         $error("pcs_bank: CID_W must lie in 1..32");
      end
      if (VMID_W < 1 || VMID_W > 16) begin : g_bad_vmid
         $error("pcs_bank: VMID_W must lie in 1..16");
      end
      if (LEVEL > 3) begin : g_bad_level
         $error("pcs_bank: LEVEL must lie in 0..3");
      end
      if (OFFSET_MODE > 2) begin : g_bad_ofs
         $error("pcs_bank: OFFSET_MODE must lie in 0..2");
      end
   endgenerate

   logic [PC_W-1:0]  live_pc;
   logic [CID_W-1:0] live_cid;
   logic [BUS_W-1:0] live_state;
   logic             live_block;
   logic [HI_W-1:0]  live_pc_hi;
   logic [HI_W-1:0]  sh_pc_hi;
   logic [CID_W-1:0] sh_cid;
   logic [BUS_W-1:0] sh_state;
   reg_sel_e         sel;
   logic             rd_phase;
   logic             rd_lo;
   logic             sample_en;
   logic             unused_wr;

   assign unused_wr  = ^pwdata;
   assign rd_phase   = psel & ~pwrite;
   assign rd_lo      = psel & penable & ~pwrite & (sel == SEL_PC_LO);
   assign sample_en  = rd_lo & ~live_block;
   assign live_pc_hi = live_pc[PC_W-1:32];

   pcs_live_stage #(
      .PC_W        (PC_W),
      .CID_W       (CID_W),
      .VMID_W      (VMID_W),
      .OFFSET_MODE (OFFSET_MODE)
   ) u_live (
      .clk           (clk),
      .rst_n         (rst_n),
      .core_pc       (core_pc),
      .core_cid      (core_cid),
      .core_vmid     (core_vmid),
      .core_ns       (core_ns),
      .core_el       (core_el),
      .core_aa64     (core_aa64),
      .core_prohibit (core_prohibit),
      .live_pc       (live_pc),
      .live_cid      (live_cid),
      .live_state    (live_state),
      .live_block    (live_block)
   );

   pcs_capture #(
      .PC_W  (PC_W),
      .CID_W (CID_W),
      .LEVEL (LEVEL)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (sample_en),
      .live_pc_hi (live_pc_hi),
      .live_cid   (live_cid),
      .live_state (live_state),
      .sh_pc_hi   (sh_pc_hi),
      .sh_cid     (sh_cid),
      .sh_state   (sh_state)
   );

   pcs_read_mux #(
      .ADDR_W      (ADDR_W),
      .LEVEL       (LEVEL),
      .OFFSET_MODE (OFFSET_MODE)
   ) u_mux (
      .rd_phase   (rd_phase),
      .paddr      (paddr),
      .live_pc_lo (live_pc[31:0]),
      .live_block (live_block),
      .sh_pc_hi   (BUS_W'(sh_pc_hi)),
      .sh_cid     (BUS_W'(sh_cid)),
      .sh_state   (sh_state),
      .sel        (sel),
      .prdata     (prdata)
   );

endmodule

// File: rtl/pcs_bank_chk.sv
module pcs_bank_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned PC_W   = 64,
   parameter int unsigned CID_W  = 32,
   parameter int unsigned LEVEL  = 3,
   localparam int unsigned HI_W  = PC_W - 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       prdata,
   input logic              rd_lo,
   input logic              live_block,
   input logic [HI_W-1:0]   live_pc_hi,
   input logic [HI_W-1:0]   sh_pc_hi,
   input logic [CID_W-1:0]  sh_cid
);

   logic lvl_rd;
   assign lvl_rd = psel & ~pwrite & ({paddr[ADDR_W-1:2], 2'b00} == ADDR_W'(12'hFC8));

   // R3
   blocked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && live_block) |-> (prdata == 32'hFFFF_FFFF));

   // R3
   blocked_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && live_block) |=> ($stable(sh_pc_hi) && $stable(sh_cid)));

   // R9
   shadow_only_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> ($stable(sh_pc_hi) && $stable(sh_cid)));

   // R6
   level_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_rd |-> (prdata == 32'(LEVEL)));

   generate
      if (LEVEL >= 1) begin : g_cap
         // R2
         capture_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lo && !live_block) |=> (sh_pc_hi == $past(live_pc_hi)));
      end
   endgenerate

endmodule

bind pcs_bank pcs_bank_chk #(
   .ADDR_W (ADDR_W),
   .PC_W   (PC_W),
   .CID_W  (CID_W),
   .LEVEL  (LEVEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .psel       (psel),
   .penable    (penable),
   .pwrite     (pwrite),
   .paddr      (paddr),
   .prdata     (prdata),
   .rd_lo      (rd_lo),
   .live_block (live_block),
   .live_pc_hi (live_pc_hi),
   .sh_pc_hi   (sh_pc_hi),
   .sh_cid     (sh_cid)
);

// File: tb/pcs_bank_bench.sv
module pcs_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata, prdata_b;
   logic [63:0] core_pc = 64'h1111_2222_3333_4444;
   logic [31:0] core_cid = 32'hC0DE_0001;
   logic [7:0]  core_vmid = 8'h5A;
   logic        core_ns = 1'b1;
   logic [1:0]  core_el = 2'd1;
   logic        core_aa64 = 1'b1;
   logic        core_prohibit = 1'b0;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   always #10 clk = ~clk;

   pcs_bank u_pcs_bank (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .core_pc(core_pc),
      .core_cid(core_cid), .core_vmid(core_vmid), .core_ns(core_ns),
      .core_el(core_el), .core_aa64(core_aa64), .core_prohibit(core_prohibit));

   pcs_bank #(.LEVEL(1), .OFFSET_MODE(2)) u_pcs_bank_lite (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b), .core_pc(core_pc),
      .core_cid(core_cid), .core_vmid(core_vmid), .core_ns(core_ns),
      .core_el(core_el), .core_aa64(core_aa64), .core_prohibit(core_prohibit));

   // Reference model: registered view of the core and the shadows of both instances.
   logic [63:0] m_pc;
   logic [31:0] m_cid, m_state;
   logic        m_prohib, m_aa64;
   logic [31:0] ma_hi, ma_cid, ma_state, mb_hi;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pc <= '0; m_cid <= '0; m_state <= '0; m_prohib <= 1'b1; m_aa64 <= 1'b0;
         ma_hi <= '0; ma_cid <= '0; ma_state <= '0; mb_hi <= '0;
      end else begin
         m_pc     <= core_pc;
         m_cid    <= core_cid;
         m_state  <= {core_ns, core_el == 2'd2, core_el == 2'd3, core_aa64, 20'h0, core_vmid};
         m_prohib <= core_prohibit;
         m_aa64   <= core_aa64;
         if (psel && penable && !pwrite && paddr[11:2] == 10'h028) begin
            if (!m_prohib) begin
               ma_hi <= m_pc[63:32]; ma_cid <= m_cid; ma_state <= m_state;
            end
            if (!m_prohib && m_aa64) mb_hi <= m_pc[63:32];
         end
      end
   end

   function automatic logic [31:0] exp_a(input logic [11:0] a);
      case ({a[11:2], 2'b00})
         12'h0A0: return m_prohib ? 32'hFFFF_FFFF : m_pc[31:0];
         12'h0A4: return ma_cid;
         12'h0A8: return ma_state;
         12'h0AC: return ma_hi;
         12'hFC4: return 32'd0;
         12'hFC8: return 32'd3;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] exp_b(input logic [11:0] a);
      case ({a[11:2], 2'b00})
         12'h0A0: return (m_prohib || !m_aa64) ? 32'hFFFF_FFFF : m_pc[31:0];
         12'h0AC: return mb_hi;
         12'hFC4: return 32'd2;
         12'hFC8: return 32'd1;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input string who, input logic [31:0] got,
                        input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %08h expected %08h", req, who, got, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, input string req);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #5;
      check(req, "full", prdata, exp_a(a));
      check(req, "lite", prdata_b, exp_b(a));
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   // Read of PC low while the core PC moves in the access cycle (R4).
   task automatic rd_collide(input logic [63:0] new_pc);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = 12'h0A0;
      @(negedge clk);
      penable = 1'b1;
      core_pc = new_pc;
      #5;
      check("R4", "full", prdata, exp_a(12'h0A0));
      check("R4", "lite", prdata_b, exp_b(12'h0A0));
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R11: shadows clear after reset
      rd(12'h0AC, "R11");
      rd(12'h0A4, "R11");
      rd(12'h0A8, "R11");

      // R2: sample then read the captured words
      rd(12'h0A0, "R2");
      rd(12'h0AC, "R2");
      rd(12'h0A4, "R2");
      rd(12'h0A8, "R5");

      // R5: other state patterns
      core_pc = 64'hAAAA_0000_BBBB_1000; core_el = 2'd2; core_ns = 1'b0; core_vmid = 8'hF1;
      core_cid = 32'h0000_0BAD;
      rd(12'h0A0, "R2");
      rd(12'h0A8, "R5");
      rd(12'h0A4, "R2");
      core_el = 2'd3; core_ns = 1'b1; core_vmid = 8'h03;
      rd(12'h0A0, "R2");
      rd(12'h0A8, "R5");

      // R6, R7: identification words
      rd(12'hFC8, "R6");
      rd(12'hFC4, "R7");

      // R1: unmapped offsets and ignored low address bits
      rd(12'h000, "R1");
      rd(12'h0B0, "R1");
      rd(12'hFCC, "R1");
      rd(12'h0AE, "R1");

      // R8: unbuilt registers of the LEVEL 1 instance
      rd(12'h0A4, "R8");
      rd(12'h0A8, "R8");

      // R3: prohibited sampling
      core_prohibit = 1'b1;
      core_pc = 64'h5555_6666_7777_8888; core_cid = 32'hDEAD_0000;
      rd(12'h0A0, "R3");
      rd(12'h0AC, "R3");
      rd(12'h0A4, "R3");
      core_prohibit = 1'b0;

      // R10: 32-bit state blocks sampling only under offset mode 2
      core_aa64 = 1'b0;
      core_pc = 64'h0123_4567_89AB_CDE1;
      rd(12'h0A0, "R10");
      rd(12'h0AC, "R10");
      core_aa64 = 1'b1;

      // R9: writes are discarded
      wr(12'h0AC, 32'hFFFF_0000);
      wr(12'h0A4, 32'h1234_5678);
      wr(12'h0A8, 32'h8765_4321);
      wr(12'hFC8, 32'h0000_000F);
      wr(12'hFC4, 32'h0000_000F);
      wr(12'h0A0, 32'hCAFE_F00D);
      rd(12'h0AC, "R9");
      rd(12'h0A4, "R9");
      rd(12'h0A8, "R9");
      rd(12'hFC8, "R9");
      rd(12'hFC4, "R9");

      // R4: PC change in the same cycle as the sample read
      core_pc = 64'h1000_0001_2000_0002;
      rd(12'h0A0, "R4");
      rd_collide(64'h3000_0003_4000_0004);
      rd(12'h0AC, "R4");
      rd(12'h0A0, "R4");
      rd(12'h0AC, "R4");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule